// File: doc/BRIEF.md
# Window-Comparator Edge Trigger Detector

This block turns a stream of 12-bit samples into a single edge-trigger event for a capture engine. It keeps one out-of-window comparator with a low and a high limit. A sample that leaves the window is a crossing of the threshold. After each crossing the limits are reloaded so that the comparator then looks for the crossing in the opposite direction. The direction of each crossing is therefore known from the limits that were loaded, and consecutive samples are never compared.

An arm pulse starts a capture. The first valid sample after arming picks the starting window from where the signal sits. A crossing in the selected polarity becomes the trigger only if the capture controller has already filled enough pre-trigger history. That means either the minimum-samples flag is set, or the write index has reached half the buffer depth. The first accepted crossing gives a one-cycle pulse, sets a sticky flag and latches the write index. Later crossings are ignored until the next arm. The threshold is an input, and mid-scale (2048) is the usual setting.

Top module: `edge_trig_top`

## Requirements
- R1: Out of reset, `trig_pulse`, `trig_flag` and `trig_idx` are all zero. Until the first `arm` pulse, no valid sample can raise `trig_flag`.
- R2: The first valid sample after `arm` is never itself a crossing. If it is strictly above `thresh`, the window becomes low=`thresh`, high=4095, which detects a falling crossing. Otherwise the window becomes low=0, high=`thresh`, which detects a rising crossing.
- R3: A crossing is a valid sample strictly below the low limit or strictly above the high limit. A sample equal to `thresh` is never a crossing.
- R4: A crossing seen while low=0 is rising, and the window is reloaded to low=`thresh`, high=4095. A crossing seen while low is nonzero is falling, and the window is reloaded to low=0, high=`thresh`. The reload happens whether or not the crossing is accepted.
- R5: A crossing whose direction differs from the selected polarity does not trigger. `rise_sel`=1 selects rising and 0 selects falling.
- R6: A matching crossing is rejected when `fill_done`=0 and `wr_idx` is below DEPTH/2. It is accepted when `fill_done`=1 or `wr_idx` is at least DEPTH/2 (512 for the default depth of 1024).
- R7: After a crossing has been accepted, later crossings leave `trig_flag`, `trig_idx` and `trig_pulse` unchanged until the next `arm`.
- R8: An accepted crossing raises `trig_pulse` for exactly one cycle, in the cycle after the crossing sample. In that same cycle `trig_flag` rises and `trig_idx` holds the `wr_idx` value that came with the crossing sample.
- R9: Cycles with `smp_valid`=0 neither choose the starting window nor count as crossings.
- R10: `arm` clears `trig_flag` and `trig_pulse` on the next cycle and closes the window until the next valid sample. `trig_idx` keeps its last value until the next accepted crossing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 12 | Sample value, unsigned |
| thresh | input | 12 | Trigger threshold |
| rise_sel | input | 1 | 1 = trigger on rising crossing, 0 = falling |
| arm | input | 1 | Start-of-capture pulse |
| fill_done | input | 1 | Capture controller has its minimum pre-trigger samples |
| wr_idx | input | 10 | Current capture write index |
| trig_pulse | output | 1 | One-cycle trigger event |
| trig_flag | output | 1 | Sticky triggered status |
| trig_idx | output | 10 | Write index latched at the trigger |

## Verification
The hardest case to reach is a crossing that is rejected because the buffer is not yet half full, while the window is still swapped. After such a crossing, a second rising sample is not a crossing at all. The bench sets `fill_done` to 0 and puts `wr_idx` one below the half mark. It then drives a rejected rising crossing and repeats high samples, some of them past the half mark, and checks that no trigger occurs. Only after a low sample re-opens the rising window does a high sample at index 512 trigger.

// File: rtl/edge_trig_pkg.sv
// Shared types for the edge trigger detector.
// Assumes unsigned sample coding, where zero is the bottom of the range.
package edge_trig_pkg;

    // Direction of a threshold crossing
    typedef enum logic {
        XDIR_UP   = 1'b0,
        XDIR_DOWN = 1'b1
    } xdir_e;

    // Tells whether a crossing matches the selected polarity (1 = rising)
    function automatic logic dir_matches(input xdir_e d, input logic rise_sel);
        return (d == XDIR_UP) ? rise_sel : !rise_sel;
    endfunction

endpackage

// File: rtl/et_window.sv
// Holds the comparator window limits.
// Arm opens a pending state. The next valid sample then chooses the starting
// window. Every later crossing reloads the limits so that the opposite
// direction is watched. Assumes evt is only raised while win_en is high.
module et_window #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    input  logic [DATA_W-1:0] thresh,
    input  logic              evt,
    output logic [DATA_W-1:0] lo_q,
    output logic [DATA_W-1:0] hi_q,
    output logic              win_en
);
    localparam logic [DATA_W-1:0] FULL = '1;

    logic init_pend;

    // Window state: choose the start window after arming, swap on each crossing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q      <= '0;
            hi_q      <= '0;
            win_en    <= 1'b0;
            init_pend <= 1'b0;
        end else if (arm) begin
            init_pend <= 1'b1;
            win_en    <= 1'b0;
        end else if (smp_valid && init_pend) begin
            init_pend <= 1'b0;
            win_en    <= 1'b1;
            if (smp_data > thresh) begin
                lo_q <= thresh;
                hi_q <= FULL;
            end else begin
                lo_q <= '0;
                hi_q <= thresh;
            end
        end else if (evt) begin
            if (lo_q == '0) begin
                lo_q <= thresh;
                hi_q <= FULL;
            end else begin
                lo_q <= '0;
                hi_q <= thresh;
            end
        end
    end

    // An open window always reaches one end of the range (R4)
    p_window_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
        win_en |-> (lo_q == '0 || hi_q == FULL));

    // A rising crossing leads to a falling-watch window (R4)
    p_swap_after_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && lo_q == '0 && !arm) |=> (hi_q == FULL && win_en));

    // A falling crossing leads to a rising-watch window (R4)
    p_swap_after_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && lo_q != '0 && !arm) |=> (lo_q == '0 && win_en));

    // Arming closes the window (R10)
    p_arm_closes_r10: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> !win_en);
endmodule

// File: rtl/et_compare.sv
// Out-of-window comparator.
// Flags a crossing on a valid sample that lies strictly outside [lo, hi], and
// reports its direction from the window that was loaded: low limit zero
// means rising. Purely combinational.
module et_compare
    import edge_trig_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              smp_valid,
    input  logic              win_en,
    input  logic [DATA_W-1:0] smp_data,
    input  logic [DATA_W-1:0] lo_q,
    input  logic [DATA_W-1:0] hi_q,
    output logic              evt,
    output xdir_e             dir
);
    // Range test and direction decode
    always_comb begin
        evt = smp_valid && win_en && ((smp_data < lo_q) || (smp_data > hi_q));
        dir = (lo_q == '0) ? XDIR_UP : XDIR_DOWN;
    end
endmodule

// File: rtl/et_qualify.sv
// Trigger qualification and latch.
// Accepts the first crossing in the selected polarity once the pre-trigger
// fill is satisfied. It then raises a one-cycle pulse, sets the sticky flag
// and records the write index. Assumes arm marks the start of a new capture.
module et_qualify
    import edge_trig_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             evt,
    input  xdir_e            dir,
    input  logic             rise_sel,
    input  logic             fill_done,
    input  logic [IDX_W-1:0] wr_idx,
    output logic             trig_pulse,
    output logic             trig_flag,
    output logic [IDX_W-1:0] trig_idx
);
    localparam logic [IDX_W-1:0] HALF_IDX = IDX_W'(DEPTH / 2);

    logic fill_ok;
    logic accept;

    // Acceptance decision for the current crossing
    always_comb begin
        fill_ok = fill_done || (wr_idx >= HALF_IDX);
        accept  = evt && dir_matches(dir, rise_sel) && fill_ok && !trig_flag;
    end

    // Trigger state: pulse, sticky flag and captured index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_pulse <= 1'b0;
            trig_flag  <= 1'b0;
            trig_idx   <= '0;
        end else if (arm) begin
            trig_pulse <= 1'b0;
            trig_flag  <= 1'b0;
        end else begin
            trig_pulse <= accept;
            if (accept) begin
                trig_flag <= 1'b1;
                trig_idx  <= wr_idx;
            end
        end
    end

    // A pulse needs a filled buffer or an index past the half mark (R6)
    p_fill_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> $past(fill_done || wr_idx >= HALF_IDX));

    // The index stays put while triggered (R7)
    p_idx_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_flag && !arm) |=> ($stable(trig_idx) && trig_flag && !trig_pulse));

    // The pulse lasts a single cycle and shows together with the flag (R8)
    p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> (trig_flag && $rose(trig_flag)));
endmodule

// File: rtl/edge_trig_top.sv
// Edge trigger detector top level.
// Joins the window store, the comparator and the qualifier. Assumes that
// smp_data, wr_idx and fill_done describe the same capture slot in a
// smp_valid cycle.
module edge_trig_top
    import edge_trig_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int DEPTH  = 1024,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    input  logic [DATA_W-1:0] thresh,
    input  logic              rise_sel,
    input  logic              arm,
    input  logic              fill_done,
    input  logic [IDX_W-1:0]  wr_idx,
    output logic              trig_pulse,
    output logic              trig_flag,
    output logic [IDX_W-1:0]  trig_idx
);
    logic [DATA_W-1:0] lo_q;
    logic [DATA_W-1:0] hi_q;
    logic              win_en;
    logic              evt;
    xdir_e             dir;

    et_window #(.DATA_W(DATA_W)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .thresh    (thresh),
        .evt       (evt),
        .lo_q      (lo_q),
        .hi_q      (hi_q),
        .win_en    (win_en)
    );

    et_compare #(.DATA_W(DATA_W)) u_compare (
        .smp_valid (smp_valid),
        .win_en    (win_en),
        .smp_data  (smp_data),
        .lo_q      (lo_q),
        .hi_q      (hi_q),
        .evt       (evt),
        .dir       (dir)
    );

    et_qualify #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_qualify (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (arm),
        .evt        (evt),
        .dir        (dir),
        .rise_sel   (rise_sel),
        .fill_done  (fill_done),
        .wr_idx     (wr_idx),
        .trig_pulse (trig_pulse),
        .trig_flag  (trig_flag),
        .trig_idx   (trig_idx)
    );

    // Every pulse comes from a valid sample (R9)
    p_pulse_from_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> $past(smp_valid));

    // Arming clears the trigger status (R10)
    p_arm_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (!trig_flag && !trig_pulse));
endmodule

// File: tb/test_edge_trig_top.sv
module test_edge_trig_top;
    localparam int DW = 12;
    localparam int DEPTH = 1024;
    localparam int IW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_valid = 1'b0;
    logic [DW-1:0] smp_data = '0;
    logic [DW-1:0] thresh = 12'd2048;
    logic          rise_sel = 1'b1;
    logic          arm = 1'b0;
    logic          fill_done = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic          trig_pulse;
    logic          trig_flag;
    logic [IW-1:0] trig_idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    edge_trig_top #(.DATA_W(DW), .DEPTH(DEPTH), .IDX_W(IW)) i_edge_trig_top (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .thresh(thresh), .rise_sel(rise_sel), .arm(arm), .fill_done(fill_done),
        .wr_idx(wr_idx), .trig_pulse(trig_pulse), .trig_flag(trig_flag),
        .trig_idx(trig_idx)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one valid sample; outputs are settled when the task returns
    task automatic push(input int d, input int idx);
        smp_valid = 1'b1;
        smp_data  = DW'(d);
        wr_idx    = IW'(idx);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic idle(input int d);
        smp_valid = 1'b0;
        smp_data  = DW'(d);
        @(negedge clk);
    endtask

    task automatic do_arm();
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 pulse", int'(trig_pulse), 0);
        chk("R1 flag", int'(trig_flag), 0);
        chk("R1 idx", int'(trig_idx), 0);
        fill_done = 1'b1;
        push(0, 600); push(4000, 600); push(0, 600); push(4000, 600);
        chk("R1 no trigger before arm", int'(trig_flag), 0);
    endtask

    task automatic t_rise_from_low();
        rise_sel = 1'b1; fill_done = 1'b1;
        do_arm();
        push(100, 30);
        chk("R2 first sample no trigger", int'(trig_flag), 0);
        push(2048, 31);
        chk("R3 equal to threshold", int'(trig_flag), 0);
        push(2049, 55);
        chk("R8 pulse", int'(trig_pulse), 1);
        chk("R8 flag", int'(trig_flag), 1);
        chk("R8 idx", int'(trig_idx), 55);
        push(2049, 56);
        chk("R8 pulse one cycle", int'(trig_pulse), 0);
    endtask

    task automatic t_start_high();
        rise_sel = 1'b1; fill_done = 1'b1;
        do_arm();
        chk("R10 flag cleared", int'(trig_flag), 0);
        chk("R10 idx kept", int'(trig_idx), 55);
        push(3000, 1);
        push(2049, 2);
        chk("R2 high start waits for fall", int'(trig_flag), 0);
        push(2048, 3);
        chk("R3 equal on falling window", int'(trig_flag), 0);
        push(2047, 4);
        chk("R5 falling mismatched", int'(trig_flag), 0);
        push(3000, 99);
        chk("R4 swapped to rising", int'(trig_flag), 1);
        chk("R4 idx", int'(trig_idx), 99);
    endtask

    task automatic t_falling_pol();
        rise_sel = 1'b0; fill_done = 1'b1;
        do_arm();
        push(100, 5);
        push(3000, 6);
        chk("R5 rising mismatched", int'(trig_flag), 0);
        push(10, 200);
        chk("R5 falling accepted", int'(trig_flag), 1);
        chk("R5 idx", int'(trig_idx), 200);
    endtask

    task automatic t_fill_gate();
        rise_sel = 1'b1; fill_done = 1'b0;
        do_arm();
        push(100, 10);
        push(3000, 511);
        chk("R6 below half rejected", int'(trig_flag), 0);
        push(3000, 600);
        chk("R4 no rise after rejected rise", int'(trig_flag), 0);
        push(100, 601);
        chk("R6 falling mismatch", int'(trig_flag), 0);
        push(3000, 512);
        chk("R6 half mark accepted", int'(trig_flag), 1);
        chk("R6 idx", int'(trig_idx), 512);
        fill_done = 1'b1;
        do_arm();
        push(0, 0);
        push(4095, 0);
        chk("R6 fill flag accepted", int'(trig_flag), 1);
        chk("R6 idx zero", int'(trig_idx), 0);
    endtask

    task automatic t_first_only();
        push(0, 3);
        push(4095, 5);
        chk("R7 pulse", int'(trig_pulse), 0);
        chk("R7 flag", int'(trig_flag), 1);
        chk("R7 idx", int'(trig_idx), 0);
    endtask

    task automatic t_valid_gate();
        rise_sel = 1'b1; fill_done = 1'b1;
        do_arm();
        idle(100);
        push(4000, 20);
        chk("R9 invalid not used as start", int'(trig_flag), 0);
        idle(0);
        chk("R9 invalid not a crossing", int'(trig_flag), 0);
        push(100, 21);
        push(4000, 77);
        chk("R9 trigger", int'(trig_flag), 1);
        chk("R9 idx", int'(trig_idx), 77);
    endtask

    task automatic t_rearm();
        do_arm();
        chk("R10 flag cleared", int'(trig_flag), 0);
        chk("R10 pulse low", int'(trig_pulse), 0);
        push(4000, 8);
        push(4095, 9);
        chk("R10 new start window", int'(trig_flag), 0);
        chk("R10 idx held", int'(trig_idx), 77);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rise_from_low();
        t_start_high();
        t_falling_pol();
        t_fill_gate();
        t_first_only();
        t_valid_gate();
        t_rearm();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule